// File: doc/BRIEF.md
# SPI FIFO Event and Interrupt Unit

This block sits beside the transmit and receive FIFOs of an SPI controller and turns their state into a software-visible event word and a level interrupt. The event word carries two live 6-bit occupancy fields. The receive field gives the number of bytes waiting to be read. The transmit field gives the transmit FIFO occupancy, from which software works out the free space. The word also holds two sticky flags: receive-not-empty and transmit-not-full. Software clears a flag by writing a one to its bit. A separate mask word enables each flag onto the interrupt output.

Each flag is held by a small two-state machine. `FLG_IDLE` means the flag reads 0. `FLG_PEND` means the flag reads 1. The transitions are:

- **arm**: `FLG_IDLE` to `FLG_PEND`, taken when the set condition holds and no clear is written in the same cycle.
- **hold**: `FLG_IDLE` to `FLG_IDLE`, taken when there is no set condition, or when a clear is written in the same cycle as the set condition.
- **stick**: `FLG_PEND` to `FLG_PEND`, taken when no clear is written.
- **ack**: `FLG_PEND` to `FLG_IDLE`, taken on a write-one-to-clear.

The receive flag's set condition is a receive push strobe or a non-zero receive level. The transmit flag's set condition is a transmit pop strobe or a transmit level below the FIFO depth.

Top module: `spi_fifo_evt_unit`

## Requirements
- R1: `event_word[29:24]` equals `rx_level` and `event_word[21:16]` equals `tx_level` in the same cycle, with no register on the path. All event-word bits other than 29:24, 21:16, 9 and 8 read 0.
- R2: The receive-not-empty flag, `event_word[9]`, reads 1 in the cycle after a cycle in which `rx_push` was 1 or `rx_level` was non-zero, unless a clear of that bit was written in that same cycle.
- R3: The transmit-not-full flag, `event_word[8]`, reads 1 in the cycle after a cycle in which `tx_pop` was 1 or `tx_level` was below `TX_DEPTH` (32), unless a clear of that bit was written in that same cycle.
- R4: A set flag stays at 1 after its condition goes away, until software clears it.
- R5: A write with `reg_wr`=1 and `reg_sel`=0 (event word) makes each flag whose `reg_wdata` bit is 1 read 0 in the next cycle. `reg_wdata[9]` targets the receive flag and `reg_wdata[8]` targets the transmit flag. A 0 in a data bit leaves that flag unchanged. When a set and a clear meet in the same cycle, the clear wins.
- R6: If a flag is cleared while its condition still holds, the flag reads 0 for exactly one cycle and then reads 1 again.
- R7: A write with `reg_wr`=1 and `reg_sel`=1 (mask word) loads `reg_wdata[9:8]` into `mask_word[9:8]`, visible in the next cycle. All other mask-word bits read 0.
- R8: `irq` is 1 exactly when (`event_word[9]` and `mask_word[9]`) or (`event_word[8]` and `mask_word[8]`), in the same cycle.
- R9: While `rst_n` is 0, both flags, the mask word and `irq` are 0.
- R10: Writing 0 to the mask word drives `irq` to 0 from the next cycle, even with both flags pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_push | input | 1 | Receive FIFO write strobe |
| rx_level | input | 6 | Receive FIFO byte occupancy |
| tx_pop | input | 1 | Transmit FIFO read strobe |
| tx_level | input | 6 | Transmit FIFO occupancy |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 = event word, 1 = mask word |
| reg_wdata | input | 2 | Write data for bit positions 9 and 8 |
| event_word | output | 32 | Event word: counts and sticky flags |
| mask_word | output | 32 | Interrupt mask word |
| irq | output | 1 | Level interrupt |

## Verification
A flag machine stuck in the wrong state shows up on `event_word` bit 9 or 8 one cycle after the stimulus that should have moved it. If the mask is also enabled, `irq` shows the same error in that same cycle. A lost clear-wins priority or a missing rearm shows up as a single wrong cycle, right after the write. The bench therefore compares every output on every clock, so one-cycle faults like these cannot slip between samples. Count fields have no state, so any fault in them is visible in the same cycle as the level input.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;

    // Bit layout of the event and mask words (software decodes these).
    localparam int WORD_W       = 32;
    localparam int FIELD_W      = 6;
    localparam int RXCNT_LSB    = 24;
    localparam int TXCNT_LSB    = 16;
    localparam int FLAG_LSB     = 8;   // bit 8: tx not-full, bit 9: rx not-empty
    localparam int NUM_FLAGS    = 2;
    localparam int FLAG_NF      = 0;
    localparam int FLAG_NE      = 1;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_PEND = 1'b1
    } flg_state_e;

    typedef enum logic {
        SEL_EVENT = 1'b0,
        SEL_MASK  = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/spi_evt_cond.sv
module spi_evt_cond #(
    parameter int CNT_W    = 6,
    parameter int TX_DEPTH = 32
) (
    input  logic             rx_push,
    input  logic [CNT_W-1:0] rx_level,
    input  logic             tx_pop,
    input  logic [CNT_W-1:0] tx_level,
    output logic             ne_set,
    output logic             nf_set
);
    localparam logic [CNT_W-1:0] TX_FULL = CNT_W'(TX_DEPTH);

    always_comb begin
        ne_set = rx_push || (rx_level != '0);
        nf_set = tx_pop  || (tx_level < TX_FULL);
    end
endmodule

// File: rtl/spi_evt_flag.sv
module spi_evt_flag
    import spi_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    flg_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    // transitions: arm, hold, stick, ack
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: if (set_i && !clr_i) state_d = FLG_PEND;
            FLG_PEND: if (clr_i)           state_d = FLG_IDLE;
            default:                       state_d = FLG_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        flag_o = (state_q == FLG_PEND);
    end
endmodule

// File: rtl/spi_evt_mask.sv
module spi_evt_mask
    import spi_evt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  logic [NUM_FLAGS-1:0] wdata_i,
    output logic [NUM_FLAGS-1:0] mask_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    mask_o <= '0;
        else if (wr_i) mask_o <= wdata_i;
    end
endmodule

// File: rtl/spi_fifo_evt_unit.sv
module spi_fifo_evt_unit
    import spi_evt_pkg::*;
#(
    parameter int CNT_W    = 6,
    parameter int TX_DEPTH = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             rx_push,
    input  logic [CNT_W-1:0]                 rx_level,
    input  logic                             tx_pop,
    input  logic [CNT_W-1:0]                 tx_level,
    input  logic                             reg_wr,
    input  logic                             reg_sel,
    input  logic [FLAG_LSB+NUM_FLAGS-1:FLAG_LSB] reg_wdata,
    output logic [WORD_W-1:0]                event_word,
    output logic [WORD_W-1:0]                mask_word,
    output logic                             irq
);
    localparam int FLAG_MSB = FLAG_LSB + NUM_FLAGS - 1;

    logic                 ne_set, nf_set;
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] clr_vec;
    logic [NUM_FLAGS-1:0] flags;
    logic [NUM_FLAGS-1:0] mask_bits;
    logic                 evt_wr, msk_wr;

    assign evt_wr = reg_wr && (reg_sel == SEL_EVENT);
    assign msk_wr = reg_wr && (reg_sel == SEL_MASK);

    spi_evt_cond #(.CNT_W(CNT_W), .TX_DEPTH(TX_DEPTH)) u_cond (
        .rx_push (rx_push),
        .rx_level(rx_level),
        .tx_pop  (tx_pop),
        .tx_level(tx_level),
        .ne_set  (ne_set),
        .nf_set  (nf_set)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[FLAG_NE] = ne_set;
        set_vec[FLAG_NF] = nf_set;
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        assign clr_vec[i] = evt_wr && reg_wdata[FLAG_LSB+i];
        spi_evt_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_vec[i]),
            .clr_i (clr_vec[i]),
            .flag_o(flags[i])
        );
    end

    spi_evt_mask u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (msk_wr),
        .wdata_i(reg_wdata),
        .mask_o (mask_bits)
    );

    always_comb begin
        event_word = '0;
        event_word[RXCNT_LSB +: FIELD_W] = FIELD_W'(rx_level);
        event_word[TXCNT_LSB +: FIELD_W] = FIELD_W'(tx_level);
        event_word[FLAG_MSB:FLAG_LSB]    = flags;
        mask_word = '0;
        mask_word[FLAG_MSB:FLAG_LSB]     = mask_bits;
        irq = |(flags & mask_bits);
    end
endmodule

// File: rtl/spi_fifo_evt_chk.sv
module spi_fifo_evt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_push,
    input logic        tx_pop,
    input logic        reg_wr,
    input logic        reg_sel,
    input logic [9:8]  reg_wdata,
    input logic [31:0] event_word,
    input logic [31:0] mask_word,
    input logic        irq
);
    logic clr_ne, clr_nf;
    assign clr_ne = reg_wr && !reg_sel && reg_wdata[9];
    assign clr_nf = reg_wr && !reg_sel && reg_wdata[8];

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((event_word[9] && mask_word[9]) || (event_word[8] && mask_word[8])));

    // R2
    ne_push_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !clr_ne) |=> event_word[9]);

    // R3
    nf_pop_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop && !clr_nf) |=> event_word[8]);

    // R5
    ne_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ne |=> !event_word[9]);

    // R4
    ne_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (event_word[9] && !clr_ne) |=> event_word[9]);

    // R7
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel) |=> (mask_word[9:8] == $past(reg_wdata)));

    // R10
    mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel && reg_wdata == 2'b00) |=> !irq);
endmodule

bind spi_fifo_evt_unit spi_fifo_evt_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_push   (rx_push),
    .tx_pop    (tx_pop),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .event_word(event_word),
    .mask_word (mask_word),
    .irq       (irq)
);

// File: tb/spi_fifo_evt_unit_tb.sv
module spi_fifo_evt_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_push = 1'b0;
    logic [5:0]  rx_level = 6'd0;
    logic        tx_pop = 1'b0;
    logic [5:0]  tx_level = 6'd32;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [9:8]  reg_wdata = 2'b00;
    logic [31:0] event_word, mask_word;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    // reference model state
    bit m_ne = 0, m_nf = 0;
    bit [1:0] m_mask = 0;

    always #5 clk = ~clk;

    spi_fifo_evt_unit u_dut (
        .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_level(rx_level),
        .tx_pop(tx_pop), .tx_level(tx_level), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .event_word(event_word), .mask_word(mask_word), .irq(irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model update
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ne = 0; m_nf = 0; m_mask = 0;
        end else begin
            bit cne, cnf;
            cne = reg_wr && !reg_sel && reg_wdata[9];
            cnf = reg_wr && !reg_sel && reg_wdata[8];
            m_ne = cne ? 1'b0 : (m_ne || rx_push || rx_level != 0);
            m_nf = cnf ? 1'b0 : (m_nf || tx_pop || tx_level < 32);
            if (reg_wr && reg_sel) m_mask = reg_wdata;
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (!finished) begin
            logic [31:0] exp_evt, exp_msk;
            exp_evt = {2'b00, rx_level, 2'b00, tx_level, 6'd0, m_ne, m_nf, 8'd0};
            exp_msk = {22'd0, m_mask, 8'd0};
            check("R1 event word", event_word, exp_evt);
            check("R7 mask word", mask_word, exp_msk);
            check("R8 irq", {31'd0, irq}, {31'd0, (m_ne & m_mask[1]) | (m_nf & m_mask[0])});
        end
    end

    task automatic drive(bit push, int rxl, bit pop, int txl, bit wr, bit sel, bit [1:0] wd);
        @(negedge clk); #1;
        rx_push = push; rx_level = 6'(rxl); tx_pop = pop; tx_level = 6'(txl);
        reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    endtask

    // read flags just after the next negedge sample point
    task automatic settle();
        @(negedge clk); #2;
    endtask

    initial begin
        #20000;
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        tx_level = 6'd0;   // NF condition true during reset
        rx_level = 6'd3;   // NE condition true during reset
        repeat (3) @(negedge clk);
        #2;
        // R9: reset holds flags, mask and irq low
        check("R9 flags in reset", {30'd0, event_word[9:8]}, 32'd0);
        check("R9 mask in reset", mask_word, 32'd0);
        check("R9 irq in reset", {31'd0, irq}, 32'd0);
        rx_level = 6'd0; tx_level = 6'd32;
        @(negedge clk); #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: push pulse with level returning to 0
        drive(1, 1, 0, 32, 0, 0, 2'b00);
        drive(0, 0, 0, 32, 0, 0, 2'b00);
        settle();
        check("R2 ne after push", {31'd0, event_word[9]}, 32'd1);
        // R4: sticky with no condition
        repeat (3) @(negedge clk); #2;
        check("R4 ne sticky", {31'd0, event_word[9]}, 32'd1);

        // R5: clear NE, NF bit written as 0
        drive(0, 0, 0, 32, 1, 0, 2'b10);
        drive(0, 0, 0, 32, 0, 0, 2'b00);
        #1 check("R5 ne cleared", {31'd0, event_word[9]}, 32'd0);
        // R5: clear wins against push in same cycle
        drive(1, 0, 0, 32, 1, 0, 2'b10);
        drive(0, 0, 0, 32, 0, 0, 2'b00);
        #1 check("R5 clear beats set", {31'd0, event_word[9]}, 32'd0);

        // R3: tx level below depth
        drive(0, 0, 0, 31, 0, 0, 2'b00);
        drive(0, 0, 0, 32, 0, 0, 2'b00);
        #1 check("R3 nf set", {31'd0, event_word[8]}, 32'd1);
        // R3: clear then tx_pop pulse
        drive(0, 0, 0, 32, 1, 0, 2'b01);
        drive(0, 0, 1, 32, 0, 0, 2'b00);
        #1 check("R5 nf cleared", {31'd0, event_word[8]}, 32'd0);
        drive(0, 0, 0, 32, 0, 0, 2'b00);
        #1 check("R3 nf after pop", {31'd0, event_word[8]}, 32'd1);

        // R6: clear while rx level still non-zero
        drive(0, 5, 0, 32, 0, 0, 2'b00);
        drive(0, 5, 0, 32, 1, 0, 2'b10);
        drive(0, 5, 0, 32, 0, 0, 2'b00);
        #1 check("R6 one-cycle low", {31'd0, event_word[9]}, 32'd0);
        drive(0, 5, 0, 32, 0, 0, 2'b00);
        #1 check("R6 rearmed", {31'd0, event_word[9]}, 32'd1);
        check("R1 rx count live", {26'd0, event_word[29:24]}, 32'd5);

        // R7/R8: enable NE only
        drive(0, 5, 0, 20, 1, 1, 2'b10);
        drive(0, 5, 0, 20, 0, 0, 2'b00);
        #1 check("R7 mask loaded", mask_word, 32'h0000_0200);
        check("R8 irq from ne", {31'd0, irq}, 32'd1);
        check("R1 tx count live", {26'd0, event_word[21:16]}, 32'd20);
        // R10: mask off with both flags pending
        drive(0, 5, 0, 20, 1, 1, 2'b00);
        drive(0, 5, 0, 20, 0, 0, 2'b00);
        #1 check("R10 irq masked", {31'd0, irq}, 32'd0);
        check("R10 flags still set", {30'd0, event_word[9:8]}, 32'd3);

        // R8: enable NF only, clear NE
        drive(0, 0, 0, 20, 1, 1, 2'b01);
        drive(0, 0, 0, 20, 1, 0, 2'b10);
        drive(0, 0, 0, 20, 0, 0, 2'b00);
        #1 check("R8 irq from nf", {31'd0, irq}, 32'd1);

        repeat (4) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule